// File: doc/BRIEF.md
# Two-Byte Serial Register Port

This block is a serial slave port through which a host processor reads and writes a small bank of 8-bit configuration registers. A transaction starts when the active-low select falls. It then moves two bytes, most significant bit first. The first byte names the register and says whether the access is a read or a write. The second byte carries the write data, or the read data on the way back. The serial inputs are oversampled on the system clock, so the serial clock must run several times slower than the system clock.

After the active-low reset is released, the port ignores the host for a fixed lockout time. The length of that time is set from the clock frequency and a millisecond count. Only one register, at address 0x10, can be read back, and only while the extended-mode input is high. The serial output is enabled only while that read is driving data.

Two pieces of the register contents are also used outside the port. A de-emphasis enable is formed from an override pin and bit 0 of register 0x00. A sticky flag reports that register 0x00 has been written at least once since reset, so that later output-pin logic can be enabled.

Top module: `regport_top`

## Requirements
- R1: A write is two bytes, shifted MSB first and sampled on rising `sck` while `cs_n` is low. The address byte has bit 7 = 0 and the register index in bits 6:0, and the data byte follows it. The register takes the data byte after the 16th rising edge.
- R2: An address byte whose bits 6:5 are not both zero (index 32 or above) writes nothing. An address byte with bit 7 = 1 (a read request) never writes, whatever data byte follows.
- R3: When `ext_mode` is high, address byte 0x90 (read of register 0x10) makes the port drive `sdo_en` high for the data byte. `sdo` presents the register value MSB first, each bit updated after a falling `sck` edge and valid at the next rising edge.
- R4: `sdo_en` stays low for a read of any other index, for any read while `ext_mode` is low, and for every write.
- R5: A transaction whose `cs_n` falling edge occurs within (CLK_HZ/1000)*LOCK_MS clock cycles after `rst_n` rises is ignored in full, even if it ends after the lockout has expired.
- R6: Raising `cs_n` before the 16th bit discards the partial transaction. The next transaction is framed from its own first bit.
- R7: `deemph_en` is high when `deemph_pin` is high, or when bit 0 of register 0x00 is 1, and is low otherwise.
- R8: `cfg_written` goes high after the first completed write to register 0x00 and stays high until reset. Writes to other registers leave it low.
- R9: While and right after reset, every register reads zero and `sdo_en` and `cfg_written` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous initial clear |
| cs_n | input | 1 | Active-low transaction select |
| sck | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_en | output | 1 | Output enable for `sdo` (high-impedance when low) |
| ext_mode | input | 1 | Extended mode, permits readback |
| deemph_pin | input | 1 | De-emphasis force-on pin |
| deemph_en | output | 1 | Effective de-emphasis enable |
| cfg_written | output | 1 | Register 0x00 has been written since reset |
| regs_flat | output | NREG*8 | All registers, index i at bits 8i+7:8i |

## Verification
The hardest case to reach is a transaction that straddles the end of the lockout. Its select falls while the port is still locked, but most of its bits arrive after the counter has expired. The bench reaches this case by starting a full write straight after reset with a shortened lockout. The frame is longer than the lockout, so the only correct result is an unchanged register bank. A second hard case is the read path, where a bit on `sdo` must settle between a falling and a rising serial edge. The bench samples `sdo` at the last system-clock edge before each rising edge.

// File: rtl/regport_pkg.sv
package regport_pkg;

    // Position inside a two-byte transaction
    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/regport_lockout.sv
module regport_lockout #(
    parameter int LOCK_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic locked
);

    localparam int CNT_W = (LOCK_CYCLES > 0) ? $clog2(LOCK_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lk_s;

    lk_s lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (lk_q.cnt != LIMIT) begin
            lk_d.cnt = lk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign locked = (lk_q.cnt != LIMIT);

endmodule

// File: rtl/regport_frame.sv
module regport_frame
    import regport_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int RD_ADDR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                locked,
    input  logic                cs_n_s,
    input  logic                sck_s,
    input  logic                sdi_s,
    input  logic                ext_mode,
    input  logic [BYTE_W-1:0]   rd_value,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                sdo,
    output logic                sdo_en,
    output logic                active
);

    localparam logic [ADDR_W-1:0] RD_IDX = ADDR_W'(RD_ADDR);

    typedef struct packed {
        logic                sck_prev;
        logic                cs_prev;
        logic                active;
        phase_e              phase;
        logic [2:0]          bitcnt;
        logic [BYTE_W-1:0]   shreg;
        logic                is_rd;
        logic                addr_ok;
        logic [ADDR_W-1:0]   addr;
        logic                rd_pend;
        logic                rd_on;
        logic [BYTE_W-1:0]   rd_sh;
        logic                wr_en;
        logic [ADDR_W-1:0]   wr_addr;
        logic [BYTE_W-1:0]   wr_data;
    } fr_s;

    fr_s fr_d, fr_q;

    logic              sck_rise;
    logic              sck_fall;
    logic              cs_fall;
    logic [BYTE_W-1:0] sh_next;
    logic [6:0]        idx7;
    logic              idx_ok;

    assign sck_rise = sck_s & ~fr_q.sck_prev;
    assign sck_fall = ~sck_s & fr_q.sck_prev;
    assign cs_fall  = fr_q.cs_prev & ~cs_n_s;
    assign sh_next  = {fr_q.shreg[BYTE_W-2:0], sdi_s};
    assign idx7     = sh_next[6:0];
    assign idx_ok   = ((idx7 >> ADDR_W) == 7'd0);

    always_comb begin
        fr_d          = fr_q;
        fr_d.wr_en    = 1'b0;
        fr_d.sck_prev = sck_s;
        fr_d.cs_prev  = cs_n_s;

        if (cs_n_s || locked) begin
            fr_d.active  = 1'b0;
            fr_d.phase   = PH_ADDR;
            fr_d.bitcnt  = '0;
            fr_d.rd_pend = 1'b0;
            fr_d.rd_on   = 1'b0;
        end else if (!fr_q.active) begin
            if (cs_fall) begin
                fr_d.active = 1'b1;
                fr_d.phase  = PH_ADDR;
                fr_d.bitcnt = '0;
            end
        end else begin
            if (sck_rise && fr_q.phase != PH_DONE) begin
                fr_d.shreg  = sh_next;
                fr_d.bitcnt = fr_q.bitcnt + 3'd1;
                if (fr_q.bitcnt == 3'd7) begin
                    if (fr_q.phase == PH_ADDR) begin
                        fr_d.is_rd   = sh_next[7];
                        fr_d.addr_ok = idx_ok;
                        fr_d.addr    = sh_next[ADDR_W-1:0];
                        fr_d.phase   = PH_DATA;
                        fr_d.rd_pend = sh_next[7] & ext_mode & idx_ok
                                     & (sh_next[ADDR_W-1:0] == RD_IDX);
                    end else begin
                        if (!fr_q.is_rd && fr_q.addr_ok) begin
                            fr_d.wr_en   = 1'b1;
                            fr_d.wr_addr = fr_q.addr;
                            fr_d.wr_data = sh_next;
                        end
                        fr_d.phase = PH_DONE;
                    end
                end
            end
            if (sck_fall) begin
                if (fr_q.rd_pend) begin
                    fr_d.rd_sh   = rd_value;
                    fr_d.rd_on   = 1'b1;
                    fr_d.rd_pend = 1'b0;
                end else if (fr_q.rd_on) begin
                    if (fr_q.phase == PH_DONE) begin
                        fr_d.rd_on = 1'b0;
                    end else begin
                        fr_d.rd_sh = {fr_q.rd_sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q          <= '0;
            fr_q.sck_prev <= 1'b1;
            fr_q.cs_prev  <= 1'b1;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign wr_en   = fr_q.wr_en;
    assign wr_addr = fr_q.wr_addr;
    assign wr_data = fr_q.wr_data;
    assign sdo     = fr_q.rd_sh[BYTE_W-1];
    assign sdo_en  = fr_q.rd_on;
    assign active  = fr_q.active;

endmodule

// File: rtl/regport_top.sv
module regport_top
    import regport_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int LOCK_MS     = 200,
    parameter int ADDR_W      = 5,
    parameter int RD_ADDR     = 16,
    parameter int DEEMPH_BIT  = 0,
    parameter int SYNC_STAGES = 2,
    localparam int NREG       = 1 << ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               sdi,
    output logic               sdo,
    output logic               sdo_en,
    input  logic               ext_mode,
    input  logic               deemph_pin,
    output logic               deemph_en,
    output logic               cfg_written,
    output logic [NREG*8-1:0]  regs_flat
);

    localparam int LOCK_CYCLES = (CLK_HZ / 1000) * LOCK_MS;
    localparam logic [ADDR_W-1:0] RD_IDX = ADDR_W'(RD_ADDR);

    logic [2:0]          pin_s;
    logic                lock_w;
    logic                act_w;
    logic                wr_en_w;
    logic [ADDR_W-1:0]   wr_addr_w;
    logic [BYTE_W-1:0]   wr_data_w;
    logic [BYTE_W-1:0]   rd_value_w;

    regport_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, sdi}),
        .q     (pin_s)
    );

    regport_lockout #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .locked (lock_w)
    );

    regport_frame #(
        .ADDR_W  (ADDR_W),
        .RD_ADDR (RD_ADDR)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked   (lock_w),
        .cs_n_s   (pin_s[2]),
        .sck_s    (pin_s[1]),
        .sdi_s    (pin_s[0]),
        .ext_mode (ext_mode),
        .rd_value (rd_value_w),
        .wr_en    (wr_en_w),
        .wr_addr  (wr_addr_w),
        .wr_data  (wr_data_w),
        .sdo      (sdo),
        .sdo_en   (sdo_en),
        .active   (act_w)
    );

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] regs;
        logic                        cfg;
    } rf_s;

    rf_s rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr_en_w) begin
            rf_d.regs[wr_addr_w] = wr_data_w;
            if (wr_addr_w == '0) begin
                rf_d.cfg = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rd_value_w  = rf_q.regs[RD_IDX];
    assign regs_flat   = rf_q.regs;
    assign cfg_written = rf_q.cfg;
    assign deemph_en   = deemph_pin | rf_q.regs[0][DEEMPH_BIT];

endmodule

// File: rtl/regport_chk.sv
module regport_chk #(
    parameter int ADDR_W = 5,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    locked,
    input  logic                    active,
    input  logic                    sdo_en,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [NREG-1:0][7:0]    regs,
    input  logic                    cfg_written
);

    logic [ADDR_W-1:0] a_q;
    logic [7:0]        d_q;
    logic [7:0]        landed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            d_q <= '0;
        end else begin
            a_q <= wr_addr;
            d_q <= wr_data;
        end
    end

    assign landed = regs[a_q];

    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (landed == d_q));

    p_drive_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en |-> active);

    p_lock_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !wr_en);

    p_lock_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !sdo_en);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_written |=> cfg_written);

    p_flag_on_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> cfg_written);

    p_reset_clean_r9: assert property (@(posedge clk)
        !rst_n |=> (!cfg_written && !sdo_en));

endmodule

bind regport_top regport_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .locked      (lock_w),
    .active      (act_w),
    .sdo_en      (sdo_en),
    .wr_en       (wr_en_w),
    .wr_addr     (wr_addr_w),
    .wr_data     (wr_data_w),
    .regs        (rf_q.regs),
    .cfg_written (cfg_written)
);

// File: tb/test_regport_top.sv
module test_regport_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int ADDR_W     = 5;
    localparam int NREG       = 1 << ADDR_W;
    localparam int CLK_HZ     = 20_000;
    localparam int LOCK_MS    = 10;

    logic clk = 1'b0;
    logic rst_n, cs_n, sck, sdi, ext_mode, deemph_pin;
    logic sdo, sdo_en, deemph_en, cfg_written;
    logic [NREG*8-1:0] regs_flat;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] mdl [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    regport_top #(
        .CLK_HZ  (CLK_HZ),
        .LOCK_MS (LOCK_MS),
        .ADDR_W  (ADDR_W)
    ) i_regport_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sck         (sck),
        .sdi         (sdi),
        .sdo         (sdo),
        .sdo_en      (sdo_en),
        .ext_mode    (ext_mode),
        .deemph_pin  (deemph_pin),
        .deemph_en   (deemph_en),
        .cfg_written (cfg_written),
        .regs_flat   (regs_flat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        for (int a = 0; a < NREG; a++) begin
            check(req, {24'd0, regs_flat[a*8 +: 8]}, {24'd0, mdl[a]});
        end
    endtask

    task automatic xfer(input logic [7:0] ab, input logic [7:0] db, input int nbits,
                        output logic [7:0] got, output int en_hits);
        got = '0;
        en_hits = 0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(posedge clk);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sck = 1'b0;
            sdi = (i < 8) ? ab[7-i] : db[15-i];
            repeat (HALF) @(posedge clk);
            @(negedge clk);
            if (i >= 8) begin
                got[15-i] = sdo;
                if (sdo_en) en_hits++;
            end
            sck = 1'b1;
            repeat (HALF) @(posedge clk);
        end
        @(negedge clk) cs_n = 1'b1;
        repeat (2*HALF) @(posedge clk);
    endtask

    task automatic wr(input logic [7:0] ab, input logic [7:0] db);
        logic [7:0] g;
        int h;
        xfer(ab, db, 16, g, h);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R9 sdo_en in reset", {31'd0, sdo_en}, 32'd0);
        rst_n = 1'b1;
        for (int a = 0; a < NREG; a++) mdl[a] = 8'h00;
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int hits;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b1; sdi = 1'b0;
        ext_mode = 1'b0; deemph_pin = 1'b0;
        do_reset();

        // R9: state just after reset
        @(negedge clk);
        check_bank("R9 bank after reset");
        check("R9 cfg_written", {31'd0, cfg_written}, 32'd0);
        check("R9 sdo_en", {31'd0, sdo_en}, 32'd0);
        check("R7 deemph off", {31'd0, deemph_en}, 32'd0);

        // R5: frame started during lockout but ending after it
        wr(8'h03, 8'hA5);
        check_bank("R5 lockout write ignored");
        wr(8'h03, 8'hA5);
        mdl[3] = 8'hA5;
        check_bank("R5 write after lockout");

        // R1 / R8: sweep every index except 0, then 0
        for (int a = NREG-1; a >= 1; a--) begin
            mdl[a] = 8'((a * 29 + 7) ^ (a << 3));
            wr(8'(a), mdl[a]);
        end
        check_bank("R1 sweep");
        check("R8 other writes keep flag low", {31'd0, cfg_written}, 32'd0);
        mdl[0] = 8'h5A;
        wr(8'h00, mdl[0]);
        check_bank("R1 index 0");
        check("R8 flag after ctrl write", {31'd0, cfg_written}, 32'd1);

        // R7: all pin/bit combinations
        for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < 2; b++) begin
                mdl[0] = {7'h2D, b[0]};
                wr(8'h00, mdl[0]);
                @(negedge clk) deemph_pin = p[0];
                @(negedge clk);
                check("R7 deemph combine", {31'd0, deemph_en}, {31'd0, p[0] | b[0]});
            end
        end
        deemph_pin = 1'b0;

        // R2: out-of-range indices and read-flag bytes write nothing
        wr(8'h25, 8'hFF);
        wr(8'h40, 8'hFF);
        wr(8'h7F, 8'hFF);
        wr(8'h83, 8'h11);
        wr(8'h80, 8'h22);
        check_bank("R2 ignored writes");

        // R3: readback of index 0x10 in extended mode
        ext_mode = 1'b1;
        mdl[16] = 8'hC3;
        wr(8'h10, mdl[16]);
        xfer(8'h90, 8'h00, 16, got, hits);
        check("R3 read value C3", {24'd0, got}, 32'hC3);
        check("R3 enable during data byte", hits, 32'd8);
        mdl[16] = 8'h3C;
        wr(8'h10, mdl[16]);
        xfer(8'h90, 8'hFF, 16, got, hits);
        check("R3 read value 3C", {24'd0, got}, 32'h3C);
        check("R3 enable count", hits, 32'd8);
        check_bank("R3 read leaves bank");
        @(negedge clk);
        check("R3 released after frame", {31'd0, sdo_en}, 32'd0);

        // R4: no drive for other reads, non-extended reads, writes
        xfer(8'h85, 8'h00, 16, got, hits);
        check("R4 read of other index", hits, 32'd0);
        xfer(8'h10, 8'h3C, 16, got, hits);
        check("R4 write frame", hits, 32'd0);
        ext_mode = 1'b0;
        xfer(8'h90, 8'h00, 16, got, hits);
        check("R4 read without ext mode", hits, 32'd0);

        // R6: aborted frames discarded, next frame aligned
        xfer(8'h05, 8'h77, 12, got, hits);
        check_bank("R6 abort in data byte");
        xfer(8'h05, 8'h77, 5, got, hits);
        check_bank("R6 abort in address byte");
        wr(8'h05, 8'h77);
        mdl[5] = 8'h77;
        check_bank("R6 next frame aligned");
        ext_mode = 1'b1;
        xfer(8'h90, 8'h00, 12, got, hits);
        @(negedge clk);
        check("R6 aborted read releases sdo", {31'd0, sdo_en}, 32'd0);
        check("R8 flag sticky", {31'd0, cfg_written}, 32'd1);

        // R9: second reset clears everything
        do_reset();
        @(negedge clk);
        check_bank("R9 bank after second reset");
        check("R9 flag after second reset", {31'd0, cfg_written}, 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule